// File: doc/BRIEF.md
# Fixed-Vector Interrupt Controller

This block decides when a small processor core must leave its instruction stream and branch to a fixed service address. Four sources can request service: an external pin, two timer overflows and a converter-done event. Each arrives as a single-cycle pulse. Each pulse sets a latched request flag. A flag is serviced only while its per-source enable is set, the global enable is set and the return stack has a free level.

When a request is taken, the block raises a one-cycle acknowledge pulse. The core uses this pulse to push the program counter and load the presented vector address. The same edge clears the global enable. The core's return-from-interrupt strobe sets it again. If the stack is full, the request is not lost. It stays pending and is taken as soon as the stack reports room again. Out of reset the vector output reads the reset address 000H.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `ack` is 0, `vec_addr` is 000H, `pending` is 0000 and `gie` is 1.
- R2: A pulse on a request input at a clock edge sets that source's bit in `pending` at that edge, whether or not the source is enabled. The bit order is external=bit0, timer0=bit1, timer1=bit2, converter=bit3.
- R3: An acknowledged source presents its own vector: external 004H, timer0 008H, timer1 00CH, converter 010H.
- R4: A request is acknowledged at the first clock edge where its bit is already visible in `pending`, its `src_en` bit is 1, `gie` is 1 and `stack_full` is 0. `ack` is then high for exactly one cycle.
- R5: When several enabled requests are pending together, the lowest bit number wins: external, then timer0, then timer1, then converter.
- R6: A pending request whose `src_en` bit is 0 is never acknowledged and stays set in `pending`.
- R7: While `stack_full` is 1 no acknowledge is issued and pending requests are kept. The first edge with `stack_full` at 0 acknowledges them.
- R8: An acknowledge clears only the chosen source's bit in `pending`. A new pulse from that source at the same edge keeps the bit set.
- R9: `gie` falls at the acknowledging edge and rises at an edge where `reti` is 1. No acknowledge is issued while `gie` is 0.
- R10: `vec_addr` changes only at an acknowledging edge and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_ext | input | 1 | External pin request pulse |
| irq_tmr0 | input | 1 | Timer 0 overflow pulse |
| irq_tmr1 | input | 1 | Timer 1 overflow pulse |
| irq_adc | input | 1 | Converter-done pulse |
| src_en | input | 4 | Per-source enables, same bit order as `pending` |
| stack_full | input | 1 | Return stack has no free level |
| reti | input | 1 | Return-from-interrupt strobe, sets `gie` |
| ack | output | 1 | One-cycle acknowledge, triggers the PC push |
| vec_addr | output | 11 | Service vector address, 000H after reset |
| pending | output | 4 | Latched request flags |
| gie | output | 1 | Global interrupt enable |

## Verification
A request pulse shows in `pending` one edge after it is driven. An enabled request produces `ack` and its vector one edge later still, so an acknowledge follows two edges after the pulse. Lowering `stack_full` or raising `reti` takes effect at the very next edge. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It compares all four outputs on the following falling edge, so every check lands in the cycle its result is due. Directed sequences cover priority, masking, stack-full hold, same-edge re-request and global-enable gating. Seeded random traffic follows them.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int ADDR_W   = 11,
  parameter int VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_ext,
  input  logic              irq_tmr0,
  input  logic              irq_tmr1,
  input  logic              irq_adc,
  input  logic [3:0]        src_en,
  input  logic              stack_full,
  input  logic              reti,
  output logic              ack,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [3:0]        pending,
  output logic              gie
);
  localparam int NSRC = 4;

  logic [NSRC-1:0]   pend_q, live, sel;
  logic [1:0]        idx;
  logic              take, ack_q, gie_q;
  logic [ADDR_W-1:0] vec_q, vec_nxt;

  assign live = pend_q & src_en;
  assign take = gie_q & ~stack_full & (|live);

  always_comb begin
    idx = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (live[i]) idx = 2'(i);
    sel = take ? (NSRC'(1) << idx) : '0;
    vec_nxt = ADDR_W'((32'(idx) + 1) * VEC_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
      gie_q  <= 1'b1;
    end else begin
      pend_q <= (pend_q & ~sel) | {irq_adc, irq_tmr1, irq_tmr0, irq_ext};
      ack_q  <= take;
      if (take) begin
        vec_q <= vec_nxt;
        gie_q <= 1'b0;
      end else if (reti) begin
        gie_q <= 1'b1;
      end
    end
  end

  assign ack      = ack_q;
  assign vec_addr = vec_q;
  assign pending  = pend_q;
  assign gie      = gie_q;

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |=> !ack);
  p_gie_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !gie);
  p_no_ack_gie_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !ack);
  p_vec_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vec_addr != '0 && (int'(vec_addr) % VEC_STEP) == 0));
  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> $stable(vec_addr));
  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending[0] && !src_en[0]) |=> pending[0]);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic clk = 0, rst_n = 0;
  logic irq_ext = 0, irq_tmr0 = 0, irq_tmr1 = 0, irq_adc = 0;
  logic [3:0] src_en = 4'hF;
  logic stack_full = 0, reti = 0;
  logic ack, gie;
  logic [10:0] vec_addr;
  logic [3:0] pending;

  int checks = 0, fails = 0;
  logic done = 0;
  logic       m_ack = 0, m_gie = 1;
  logic [10:0] m_vec = 0;
  logic [3:0] m_pend = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_ext(irq_ext), .irq_tmr0(irq_tmr0),
    .irq_tmr1(irq_tmr1), .irq_adc(irq_adc), .src_en(src_en), .stack_full(stack_full),
    .reti(reti), .ack(ack), .vec_addr(vec_addr), .pending(pending), .gie(gie));

  function automatic logic [10:0] vec_of(int i);
    case (i)
      0: return 11'h004;
      1: return 11'h008;
      2: return 11'h00C;
      default: return 11'h010;
    endcase
  endfunction

  function automatic int first_set(logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "ack", ack, m_ack);
    chk(tag, "vec_addr", vec_addr, m_vec);
    chk(tag, "pending", pending, m_pend);
    chk(tag, "gie", gie, m_gie);
  endtask

  task automatic step(logic [3:0] req, logic [3:0] en, logic full, logic ret, string tag);
    logic [3:0] live;
    logic take;
    int p;
    {irq_adc, irq_tmr1, irq_tmr0, irq_ext} = req;
    src_en = en; stack_full = full; reti = ret;
    @(posedge clk);
    live = m_pend & en;
    take = m_gie && !full && (live != 0);
    p = first_set(live);
    m_pend = (m_pend & ~(take ? (4'b1 << p) : 4'b0)) | req;
    m_ack = take;
    if (take) begin m_vec = vec_of(p); m_gie = 0; end
    else if (ret) m_gie = 1;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // single external request, then return
    step(4'b0001, 4'hF, 0, 0, "R2");
    step(4'b0000, 4'hF, 0, 0, "R3");
    chk("R4", "ack", ack, 1);
    step(4'b0000, 4'hF, 0, 0, "R4");
    chk("R4", "ack_low", ack, 0);
    step(4'b0000, 4'hF, 0, 1, "R9");

    // all four at once: priority order
    step(4'b1111, 4'hF, 0, 0, "R2");
    step(4'b0000, 4'hF, 0, 0, "R5");
    chk("R5", "vec_addr", vec_addr, 11'h004);
    for (int k = 0; k < 3; k++) begin
      step(4'b0000, 4'hF, 0, 1, "R9");
      step(4'b0000, 4'hF, 0, 0, "R5");
    end
    chk("R5", "last_vec", vec_addr, 11'h010);
    step(4'b0000, 4'hF, 0, 1, "R9");

    // masked source stays pending
    step(4'b0100, 4'h0, 0, 0, "R6");
    for (int k = 0; k < 4; k++) step(4'b0000, 4'hB, 0, 0, "R6");
    chk("R6", "pending", pending, 4'b0100);
    step(4'b0000, 4'hF, 0, 0, "R3");
    chk("R3", "vec_tmr1", vec_addr, 11'h00C);
    step(4'b0000, 4'hF, 0, 1, "R9");

    // stack full hold
    step(4'b1000, 4'hF, 1, 0, "R7");
    for (int k = 0; k < 4; k++) step(4'b0000, 4'hF, 1, 0, "R7");
    chk("R7", "held", pending, 4'b1000);
    step(4'b0000, 4'hF, 0, 0, "R7");
    chk("R7", "vec_adc", vec_addr, 11'h010);
    step(4'b0000, 4'hF, 0, 1, "R9");

    // selective clear and same-edge re-request
    step(4'b0011, 4'hF, 0, 0, "R8");
    step(4'b0001, 4'hF, 0, 0, "R8");
    chk("R8", "pending", pending, 4'b0011);
    // gie low: nothing taken, vector holds
    for (int k = 0; k < 3; k++) step(4'b0000, 4'hF, 0, 0, "R9");
    chk("R10", "vec_hold", vec_addr, 11'h004);
    chk("R9", "no_ack", ack, 0);
    step(4'b0000, 4'hF, 0, 1, "R9");
    step(4'b0000, 4'hF, 0, 0, "R5");
    chk("R5", "vec_ext", vec_addr, 11'h004);
    step(4'b0000, 4'hF, 0, 1, "R9");

    // seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] rq, en;
      rq = 0;
      for (int b = 0; b < 4; b++) rq[b] = ($urandom % 8) == 0;
      en = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
      step(rq, en, ($urandom % 4) == 0, ($urandom % 5) == 0, "R2/R4/R10 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule